// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns a decoded operand addressing mode into a 24-bit effective address for a CPU whose address registers are 32 bits wide and whose memory space is 16 Mbytes. Each request carries the mode, the operand size, the selected register value, the current program counter and the instruction's extension field (a displacement, absolute address or immediate). One cycle later the block returns the address, a flag saying the operand needs no memory access, and, for the auto-modifying modes, the register value to write back.

Memory-indirect operands need a pointer fetch. The block raises a fetch request to the top page of memory, holds it until the memory side answers, and takes the low 24 bits of the returned longword as the operand address. While that fetch is pending the block reports itself busy and ignores new requests.

Top module: `opaddr_unit`

## Requirements
- R1: During and right after reset, `out_valid`, `ptr_req` and `busy` are low.
- R2: Mode code 1 (register indirect) returns the low 24 bits of `in_reg` as the address, with `out_nomem`=0, `out_wb_en`=0 and `out_wb_val`=0.
- R3: Mode code 2 adds the low 16 bits of `in_field`, sign-extended, to `in_reg`; mode code 3 adds all 32 bits of `in_field`; both keep the low 24 bits of the sum.
- R4: Mode code 11 adds the low 8 bits of `in_field`, sign-extended, to `in_pc`; mode code 12 does the same with the low 16 bits; the result wraps within 24 bits.
- R5: Mode code 4 (post-increment) uses the low 24 bits of `in_reg` as the address and writes back `in_reg` plus a step of 1, 2 or 4 for `in_size` 0, 1 or 2 (size code 3 steps by 4), with `out_wb_en`=1.
- R6: Mode code 5 (pre-decrement) subtracts the same step from `in_reg`, writes back the 32-bit difference with `out_wb_en`=1, and uses its low 24 bits as the address.
- R7: Absolute modes: code 6 places the low 8 bits of `in_field` under sixteen one bits; code 7 sign-extends the low 16 bits; codes 8 and 9 take the low 24 bits; field bits above each width have no effect.
- R8: Mode codes 0 (register direct), 10 (immediate) and the unused codes 14 and 15 return `out_nomem`=1, address 0, `out_wb_en`=0 and `out_wb_val`=0.
- R9: Mode code 13 (memory indirect) raises `ptr_req` one cycle after the request with `ptr_addr` equal to sixteen one bits above the low 8 bits of `in_field`, holds both until `ptr_valid` is sampled high, and one cycle later returns the low 24 bits of `ptr_data` with `out_nomem`=0 and `out_wb_en`=0.
- R10: `busy` is high while a pointer fetch is pending; a request presented while busy produces no result and is dropped.
- R11: Every request accepted while not busy, other than code 13, yields exactly one `out_valid` pulse in the following cycle; back-to-back requests give back-to-back results in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 4 | Addressing mode code |
| in_size | input | 2 | Operand size: 0 byte, 1 word, 2 longword |
| in_reg | input | 32 | Selected address register value |
| in_pc | input | 24 | Current program counter |
| in_field | input | 32 | Displacement, absolute or immediate field |
| busy | output | 1 | Pointer fetch pending |
| out_valid | output | 1 | Result strobe |
| out_ea | output | 24 | Effective address |
| out_nomem | output | 1 | Operand needs no memory access |
| out_wb_en | output | 1 | Register write-back required |
| out_wb_val | output | 32 | Register write-back value |
| ptr_req | output | 1 | Pointer fetch request |
| ptr_addr | output | 24 | Pointer location |
| ptr_valid | input | 1 | Pointer data valid |
| ptr_data | input | 32 | Returned pointer longword |

## Verification
The hardest case to reach is a new request arriving while a pointer fetch is still outstanding, since it needs a memory response held back on purpose. The bench answers pointer fetches itself with a chosen delay of zero or several cycles, and during the longer waits it presents a register-indirect request that must vanish without a result. The scoreboard then proves the drop: any stray result pulls the next expected item out of order and mismatches.

// File: rtl/opaddr_pkg.sv
// Shared constants for the operand address generator.
// Assumes a 4-bit mode code and a 2-bit size code at the block edge.
package opaddr_pkg;
    localparam logic [3:0] AM_REG     = 4'd0;
    localparam logic [3:0] AM_IND     = 4'd1;
    localparam logic [3:0] AM_DISP16  = 4'd2;
    localparam logic [3:0] AM_DISP32  = 4'd3;
    localparam logic [3:0] AM_POSTINC = 4'd4;
    localparam logic [3:0] AM_PREDEC  = 4'd5;
    localparam logic [3:0] AM_ABS8    = 4'd6;
    localparam logic [3:0] AM_ABS16   = 4'd7;
    localparam logic [3:0] AM_ABS24   = 4'd8;
    localparam logic [3:0] AM_ABS32   = 4'd9;
    localparam logic [3:0] AM_IMM     = 4'd10;
    localparam logic [3:0] AM_PCREL8  = 4'd11;
    localparam logic [3:0] AM_PCREL16 = 4'd12;
    localparam logic [3:0] AM_MEMIND  = 4'd13;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    typedef enum logic {
        IND_IDLE  = 1'b0,
        IND_FETCH = 1'b1
    } ind_state_e;
endpackage

// File: rtl/opaddr_step.sv
// Auto-modify step: the byte count of one operand of the given size.
// Assumes size code 0 byte, 1 word, anything else longword.
module opaddr_step #(
    parameter int DW = 32
) (
    input  logic [1:0]    size,
    output logic [DW-1:0] step
);
    import opaddr_pkg::*;

    // Map the size code to a 1, 2 or 4 byte step.
    always_comb begin
        case (size)
            SZ_BYTE: step = DW'(1);
            SZ_WORD: step = DW'(2);
            default: step = DW'(4);
        endcase
    end
endmodule

// File: rtl/opaddr_calc.sv
// Combinational address former for every single-cycle mode.
// Assumes AW >= 16 and DW >= AW; memory-indirect only raises is_ind here.
module opaddr_calc #(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic [3:0]    mode,
    input  logic [1:0]    size,
    input  logic [DW-1:0] reg_val,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] field,
    output logic [AW-1:0] ea,
    output logic          nomem,
    output logic          wb_en,
    output logic [DW-1:0] wb_val,
    output logic          is_ind
);
    import opaddr_pkg::*;

    localparam int SHORT_W = 8;
    localparam int HALF_W  = 16;

    logic [DW-1:0] step;
    logic [DW-1:0] disp16_x;
    logic [AW-1:0] pc_d8_x;
    logic [AW-1:0] pc_d16_x;
    logic [AW-1:0] abs8_x;
    logic [AW-1:0] abs16_x;
    logic [DW-1:0] reg_inc;
    logic [DW-1:0] reg_dec;
    logic [DW-1:0] reg_d16;
    logic [DW-1:0] reg_d32;

    opaddr_step #(.DW(DW)) u_step (
        .size (size),
        .step (step)
    );

    // Field extensions and the candidate sums for each mode.
    always_comb begin
        disp16_x = {{(DW-HALF_W){field[HALF_W-1]}}, field[HALF_W-1:0]};
        pc_d8_x  = {{(AW-SHORT_W){field[SHORT_W-1]}}, field[SHORT_W-1:0]};
        pc_d16_x = {{(AW-HALF_W){field[HALF_W-1]}}, field[HALF_W-1:0]};
        abs8_x   = {{(AW-SHORT_W){1'b1}}, field[SHORT_W-1:0]};
        abs16_x  = {{(AW-HALF_W){field[HALF_W-1]}}, field[HALF_W-1:0]};
        reg_inc  = reg_val + step;
        reg_dec  = reg_val - step;
        reg_d16  = reg_val + disp16_x;
        reg_d32  = reg_val + field;
    end

    // Select the address, access flag and write-back for the decoded mode.
    always_comb begin
        ea     = '0;
        nomem  = 1'b0;
        wb_en  = 1'b0;
        wb_val = '0;
        is_ind = 1'b0;
        case (mode)
            AM_IND:     ea = reg_val[AW-1:0];
            AM_DISP16:  ea = reg_d16[AW-1:0];
            AM_DISP32:  ea = reg_d32[AW-1:0];
            AM_POSTINC: begin
                ea     = reg_val[AW-1:0];
                wb_en  = 1'b1;
                wb_val = reg_inc;
            end
            AM_PREDEC: begin
                ea     = reg_dec[AW-1:0];
                wb_en  = 1'b1;
                wb_val = reg_dec;
            end
            AM_ABS8:    ea = abs8_x;
            AM_ABS16:   ea = abs16_x;
            AM_ABS24,
            AM_ABS32:   ea = field[AW-1:0];
            AM_PCREL8:  ea = pc + pc_d8_x;
            AM_PCREL16: ea = pc + pc_d16_x;
            AM_MEMIND:  is_ind = 1'b1;
            default:    nomem = 1'b1;
        endcase
    end
endmodule

// File: rtl/opaddr_indfsm.sv
// Pointer-fetch sequencer for memory-indirect operands.
// Assumes the memory side may answer in any cycle once ptr_req is high.
module opaddr_indfsm #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    ptr_lo,
    input  logic          ptr_valid,
    output logic          busy,
    output logic          ptr_req,
    output logic [AW-1:0] ptr_addr,
    output logic          done
);
    import opaddr_pkg::*;

    ind_state_e state;

    // Move between idle and fetch, capturing the pointer location on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= IND_IDLE;
            ptr_addr <= '0;
        end else begin
            case (state)
                IND_IDLE: if (start) begin
                    state    <= IND_FETCH;
                    ptr_addr <= {{(AW-8){1'b1}}, ptr_lo};
                end
                IND_FETCH: if (ptr_valid) state <= IND_IDLE;
                default: state <= IND_IDLE;
            endcase
        end
    end

    // Status and handshake derived from the state register.
    always_comb begin
        busy    = (state == IND_FETCH);
        ptr_req = (state == IND_FETCH);
        done    = (state == IND_FETCH) && ptr_valid;
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req && !ptr_valid) |=> (ptr_req && $stable(ptr_addr))); // R9
    AST_PTR_TOP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_req |-> (&ptr_addr[AW-1:8])); // R9
endmodule

// File: rtl/opaddr_unit.sv
// Operand effective address generator, top level.
// Registers one result per accepted request; memory-indirect requests go
// through the pointer-fetch sequencer and return when the pointer arrives.
module opaddr_unit #(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    in_mode,
    input  logic [1:0]    in_size,
    input  logic [DW-1:0] in_reg,
    input  logic [AW-1:0] in_pc,
    input  logic [DW-1:0] in_field,
    output logic          busy,
    output logic          out_valid,
    output logic [AW-1:0] out_ea,
    output logic          out_nomem,
    output logic          out_wb_en,
    output logic [DW-1:0] out_wb_val,
    output logic          ptr_req,
    output logic [AW-1:0] ptr_addr,
    input  logic          ptr_valid,
    input  logic [DW-1:0] ptr_data
);
    logic [AW-1:0] c_ea;
    logic          c_nomem;
    logic          c_wb_en;
    logic [DW-1:0] c_wb_val;
    logic          c_is_ind;
    logic          accept;
    logic          ind_done;

    opaddr_calc #(.AW(AW), .DW(DW)) u_calc (
        .mode    (in_mode),
        .size    (in_size),
        .reg_val (in_reg),
        .pc      (in_pc),
        .field   (in_field),
        .ea      (c_ea),
        .nomem   (c_nomem),
        .wb_en   (c_wb_en),
        .wb_val  (c_wb_val),
        .is_ind  (c_is_ind)
    );

    // A request is taken only while no pointer fetch is pending.
    always_comb accept = in_valid && !busy;

    opaddr_indfsm #(.AW(AW)) u_ind (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept && c_is_ind),
        .ptr_lo    (in_field[7:0]),
        .ptr_valid (ptr_valid),
        .busy      (busy),
        .ptr_req   (ptr_req),
        .ptr_addr  (ptr_addr),
        .done      (ind_done)
    );

    // Result register: direct results one cycle after accept, indirect ones after the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_ea     <= '0;
            out_nomem  <= 1'b0;
            out_wb_en  <= 1'b0;
            out_wb_val <= '0;
        end else if (accept && !c_is_ind) begin
            out_valid  <= 1'b1;
            out_ea     <= c_ea;
            out_nomem  <= c_nomem;
            out_wb_en  <= c_wb_en;
            out_wb_val <= c_wb_val;
        end else if (ind_done) begin
            out_valid  <= 1'b1;
            out_ea     <= ptr_data[AW-1:0];
            out_nomem  <= 1'b0;
            out_wb_en  <= 1'b0;
            out_wb_val <= '0;
        end else begin
            out_valid  <= 1'b0;
        end
    end

    AST_IND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req && ptr_valid) |=> (out_valid && out_ea == $past(ptr_data[AW-1:0]))); // R9
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ptr_valid) |=> !out_valid); // R10
    AST_NOMEM_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nomem) |-> (!out_wb_en && out_ea == '0)); // R8
    AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> (out_valid || ptr_req)); // R11
endmodule

// File: tb/tb_opaddr_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected results, a negedge monitor compares.
module tb_opaddr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_mode = '0;
    logic [1:0]  in_size = '0;
    logic [31:0] in_reg = '0;
    logic [23:0] in_pc = '0;
    logic [31:0] in_field = '0;
    logic        busy, out_valid, out_nomem, out_wb_en, ptr_req;
    logic [23:0] out_ea, ptr_addr;
    logic [31:0] out_wb_val;
    logic        ptr_valid = 1'b0;
    logic [31:0] ptr_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [57:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    opaddr_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_size(in_size), .in_reg(in_reg), .in_pc(in_pc), .in_field(in_field),
        .busy(busy), .out_valid(out_valid), .out_ea(out_ea), .out_nomem(out_nomem),
        .out_wb_en(out_wb_en), .out_wb_val(out_wb_val), .ptr_req(ptr_req),
        .ptr_addr(ptr_addr), .ptr_valid(ptr_valid), .ptr_data(ptr_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each result pulse against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", "unexpected result", {6'd0, out_ea, out_nomem, out_wb_en, out_wb_val}, 64'd0);
            end else begin
                logic [57:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({out_ea, out_nomem, out_wb_en, out_wb_val} == e, t, "result {ea,nomem,wb_en,wb}",
                    {6'd0, out_ea, out_nomem, out_wb_en, out_wb_val}, {6'd0, e});
            end
        end
    end

    // Drive one request for a cycle and queue its expected result.
    task automatic send(input logic [3:0] m, input logic [1:0] s, input logic [31:0] r,
                        input logic [23:0] pc, input logic [31:0] f, input logic [23:0] ea,
                        input logic nm, input logic we, input logic [31:0] wb, input string tag);
        in_valid = 1'b1; in_mode = m; in_size = s; in_reg = r; in_pc = pc; in_field = f;
        exp_q.push_back({ea, nm, we, wb});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    // Memory-indirect request answered after dly cycles; optionally pokes a request while busy.
    task automatic memind(input logic [31:0] f, input logic [31:0] data, input int dly, input bit poke);
        logic [23:0] a0;
        in_valid = 1'b1; in_mode = 4'd13; in_field = f;
        exp_q.push_back({data[23:0], 1'b0, 1'b0, 32'd0});
        tag_q.push_back("R9");
        @(negedge clk);
        in_valid = 1'b0;
        if (poke && dly > 0) begin
            in_valid = 1'b1; in_mode = 4'd1; in_reg = 32'h0055_AA55;
        end
        chk(ptr_req == 1'b1, "R9", "ptr_req raised", {63'd0, ptr_req}, 64'd1);
        chk(ptr_addr == {16'hFFFF, f[7:0]}, "R9", "ptr_addr", {40'd0, ptr_addr}, {40'd0, 16'hFFFF, f[7:0]});
        chk(busy == 1'b1, "R10", "busy during fetch", {63'd0, busy}, 64'd1);
        a0 = ptr_addr;
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk(ptr_req == 1'b1 && ptr_addr == a0, "R9", "request held",
                {39'd0, ptr_req, ptr_addr}, {39'd1, a0});
        end
        ptr_valid = 1'b1; ptr_data = data;
        @(negedge clk);
        ptr_valid = 1'b0;
        chk(ptr_req == 1'b0 && busy == 1'b0, "R10", "fetch released",
            {62'd0, ptr_req, busy}, 64'd0);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !ptr_req && !busy, "R1", "outputs in reset",
            {61'd0, out_valid, ptr_req, busy}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !ptr_req && !busy, "R1", "outputs after reset",
            {61'd0, out_valid, ptr_req, busy}, 64'd0);

        send(4'd1, 2'd0, 32'hAB12_3456, 24'h0, 32'h0, 24'h123456, 0, 0, 32'h0, "R2");
        idle();
        // Back-to-back stream (R11) mixing displacement and PC-relative forms.
        send(4'd2, 2'd0, 32'h0000_1000, 24'h0, 32'h0000_FFF0, 24'h000FF0, 0, 0, 32'h0, "R3");
        send(4'd2, 2'd1, 32'h00FF_FFF0, 24'h0, 32'hFFFF_0020, 24'h000010, 0, 0, 32'h0, "R3");
        send(4'd3, 2'd2, 32'h0010_0000, 24'h0, 32'h1234_5678, 24'h445678, 0, 0, 32'h0, "R3");
        send(4'd11, 2'd0, 32'h0, 24'h001000, 32'h0000_0080, 24'h000F80, 0, 0, 32'h0, "R4");
        send(4'd12, 2'd0, 32'h0, 24'h000100, 32'h0000_7FFF, 24'h0080FF, 0, 0, 32'h0, "R4");
        send(4'd12, 2'd0, 32'h0, 24'h010000, 32'h0000_8000, 24'h008000, 0, 0, 32'h0, "R4");
        send(4'd11, 2'd0, 32'h0, 24'hFFFFFF, 32'h0000_0002, 24'h000001, 0, 0, 32'h0, "R4");
        idle();
        send(4'd4, 2'd0, 32'h00FF_FFFF, 24'h0, 32'h0, 24'hFFFFFF, 0, 1, 32'h0100_0000, "R5");
        send(4'd4, 2'd1, 32'h0000_2000, 24'h0, 32'h0, 24'h002000, 0, 1, 32'h0000_2002, "R5");
        send(4'd4, 2'd2, 32'h0000_2000, 24'h0, 32'h0, 24'h002000, 0, 1, 32'h0000_2004, "R5");
        send(4'd4, 2'd3, 32'h0000_2000, 24'h0, 32'h0, 24'h002000, 0, 1, 32'h0000_2004, "R5");
        send(4'd5, 2'd2, 32'h0000_0002, 24'h0, 32'h0, 24'hFFFFFE, 0, 1, 32'hFFFF_FFFE, "R6");
        send(4'd5, 2'd0, 32'h0000_0100, 24'h0, 32'h0, 24'h0000FF, 0, 1, 32'h0000_00FF, "R6");
        send(4'd5, 2'd1, 32'h0000_0100, 24'h0, 32'h0, 24'h0000FE, 0, 1, 32'h0000_00FE, "R6");
        idle();
        send(4'd6, 2'd0, 32'h0, 24'h0, 32'h1234_5642, 24'hFFFF42, 0, 0, 32'h0, "R7");
        send(4'd7, 2'd0, 32'h0, 24'h0, 32'h0000_8001, 24'hFF8001, 0, 0, 32'h0, "R7");
        send(4'd7, 2'd0, 32'h0, 24'h0, 32'hFFFF_7FFF, 24'h007FFF, 0, 0, 32'h0, "R7");
        send(4'd8, 2'd0, 32'h0, 24'h0, 32'hAB12_3456, 24'h123456, 0, 0, 32'h0, "R7");
        send(4'd9, 2'd0, 32'h0, 24'h0, 32'h89AB_CDEF, 24'hABCDEF, 0, 0, 32'h0, "R7");
        idle();
        send(4'd0, 2'd2, 32'h1234_5678, 24'h0, 32'h0000_0010, 24'h0, 1, 0, 32'h0, "R8");
        send(4'd10, 2'd1, 32'h1234_5678, 24'h0, 32'h1234_5678, 24'h0, 1, 0, 32'h0, "R8");
        send(4'd14, 2'd0, 32'h0000_0004, 24'h0, 32'h0, 24'h0, 1, 0, 32'h0, "R8");
        send(4'd15, 2'd0, 32'h0000_0004, 24'h0, 32'h0, 24'h0, 1, 0, 32'h0, "R8");
        idle();
        memind(32'h0000_005A, 32'hDE65_4321, 3, 1'b1);
        memind(32'hFFFF_FF01, 32'h00AB_CDEF, 0, 1'b0);
        send(4'd1, 2'd0, 32'h0000_0777, 24'h0, 32'h0, 24'h000777, 0, 0, 32'h0, "R10");
        idle();
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R11", "all results delivered", 64'(exp_q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule